// File: doc/BRIEF.md
# 16-bit Timer with Buffered Byte Access

This block is a 16-bit up-counting timer/counter that sits on an 8-bit register bus. It counts either an internal clock-enable strobe or an external count pulse through a selectable divide-by-1/2/4/8 prescaler. When the count wraps from 0xFFFF to 0x0000 it sets a sticky overflow flag, and that flag raises an interrupt line when its enable bit is set. An external compare-match event can clear the count, so a compare value acts as the timer period.

Software reaches the 16-bit count one byte at a time. In buffered mode the high byte sits behind a shadow register. Reading the low byte captures the high byte in the same instant, and writing the low byte commits a previously written high byte. As a result, all 16 bits are read or written as one coherent value, even while the count is running.

Register map (byte address on `bus_addr`): 0 = count low byte, 1 = count high byte, 2 = control, 3 = interrupt (bit 0 flag, bit 1 enable). The read data is combinational from the selected register.

Top module: `tmr16_core`

## Requirements
- R1: The count increments by one on each prescaler terminal pulse while the control run bit (bit 0) is 1. It wraps from 0xFFFF to 0x0000, and that wrap sets the overflow flag (interrupt register bit 0), which stays set until software clears it.
- R2: `irq` is high exactly when the overflow flag and the interrupt enable (interrupt register bit 1) are both 1. Writing address 3 loads the enable from data bit 1. It clears the flag when data bit 0 is 0 and leaves the flag alone when data bit 0 is 1. If a wrap happens in the same cycle as a clearing write, the flag ends up set.
- R3: The control register (address 2) has these fields: bit 7 buffered access, bit 6 unused and always read as 0, bits 5:4 prescaler select, bit 3 oscillator enable (stored only), bit 2 sync bypass, bit 1 external source, bit 0 run. Every implemented bit resets to 0.
- R4: Prescaler select codes 00, 01, 10 and 11 divide the count source by 1, 2, 4 and 8.
- R5: In buffered mode (control bit 7 = 1), a read of address 0 copies the live high byte into the shadow register. A read of address 1 returns the shadow register, not the live high byte.
- R6: In buffered mode, a write to address 1 changes only the shadow register. A write to address 0 then loads the whole count with {shadow, write data} in one cycle.
- R7: With buffered mode off, addresses 0 and 1 read the live count bytes. A write to either address replaces that byte of the count directly.
- R8: A write to address 0 clears the prescaler. A write to address 1 leaves the prescaler phase untouched.
- R9: A high pulse on `evt_trig` clears the count to 0x0000 in timer mode (bit 1 = 0) and in synchronized counter mode (bits 2:1 = 01). In unsynchronized counter mode (bits 2:1 = 11) the trigger is ignored.
- R10: If a bus write to address 0 or 1 falls in the same cycle as a trigger, the write takes effect and the trigger is ignored. A trigger clear never sets the overflow flag, even when the count is 0xFFFF.
- R11: In synchronized counter mode, each rising edge of `ext_pulse`, seen through a two-flop synchronizer, is one count event. In unsynchronized counter mode, every cycle in which `ext_pulse` is high is one count event.
- R12: After reset the count, the shadow register, the flag and the enable are all 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the shadow capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| tick_en | input | 1 | Internal count strobe, one event per high cycle |
| ext_pulse | input | 1 | External count input |
| evt_trig | input | 1 | Compare-match trigger, clears the count |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and a two-bit prescaler code, giving divide ratios up to 8. These values make every prescaler phase reachable within eight stimulus cycles, and they make the synchronizer latency short enough to observe edge counting directly. Because the 16-bit count can be preloaded through the bus, the wrap at 0xFFFF and the trigger-against-wrap collision can both be reached without long counting runs.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int DIV_CODE_W = 2;
    localparam int PS_CNT_W   = (1 << DIV_CODE_W) - 1;
    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_INT    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                  buf16;
        logic                  rsv;
        logic [DIV_CODE_W-1:0] div_sel;
        logic                  osc_en;
        logic                  no_sync;
        logic                  ext_src;
        logic                  run;
    } ctrl_t;

    function automatic logic [PS_CNT_W-1:0] div_limit(input logic [DIV_CODE_W-1:0] code);
        return PS_CNT_W'((1 << code) - 1);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_view(input ctrl_t c);
        return {c.buf16, 1'b0, c.div_sel, c.osc_en, c.no_sync, c.ext_src, c.run};
    endfunction

endpackage

// File: rtl/tmr16_srcsel.sv
module tmr16_srcsel
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_src,
    input  logic no_sync,
    input  logic tick_en,
    input  logic ext_pulse,
    output logic src_ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= (i == 0) ? ext_pulse : sync_q[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;

    always_comb begin
        if (!ext_src)     src_ev = tick_en;
        else if (no_sync) src_ev = ext_pulse;
        else              src_ev = rise;
    end

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler
    import tmr16_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  ev,
    input  logic [DIV_CODE_W-1:0] div_sel,
    output logic                  tc
);
    logic [PS_CNT_W-1:0] ps_q;

    assign tc = ev && (ps_q >= div_limit(div_sel));

    always_ff @(posedge clk) begin
        if (rst || clr) ps_q <= '0;
        else if (ev)    ps_q <= tc ? '0 : ps_q + 1'b1;
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_en,
    input  logic       ext_pulse,
    input  logic       evt_trig,
    output logic       irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  shadow_q;
    logic               flag_q;
    logic               ie_q;

    logic wr_lo, wr_hi, wr_ctl, wr_int, rd_lo;
    logic src_ev, tc, trig_ok, trig_hit, cnt_load, ovf;

    assign wr_lo  = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi  = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_ctl = bus_wr && (bus_addr == A_CTRL);
    assign wr_int = bus_wr && (bus_addr == A_INT);
    assign rd_lo  = bus_rd && (bus_addr == A_CNT_LO);

    tmr16_srcsel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst       (rst),
        .ext_src   (ctrl_q.ext_src),
        .no_sync   (ctrl_q.no_sync),
        .tick_en   (tick_en),
        .ext_pulse (ext_pulse),
        .src_ev    (src_ev)
    );

    tmr16_prescaler u_ps (
        .clk     (clk),
        .rst     (rst),
        .clr     (wr_lo),
        .ev      (src_ev && ctrl_q.run),
        .div_sel (ctrl_q.div_sel),
        .tc      (tc)
    );

    assign trig_ok  = !(ctrl_q.ext_src && ctrl_q.no_sync);
    assign trig_hit = evt_trig && trig_ok && !wr_lo && !wr_hi;
    assign cnt_load = wr_lo || (wr_hi && !ctrl_q.buf16);
    assign ovf      = tc && !cnt_load && !trig_hit && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q <= {(ctrl_q.buf16 ? shadow_q : cnt_q[CNT_W-1:BYTE_W]), bus_wdata};
        end else if (wr_hi && !ctrl_q.buf16) begin
            cnt_q[CNT_W-1:BYTE_W] <= bus_wdata;
        end else if (trig_hit) begin
            cnt_q <= '0;
        end else if (tc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          shadow_q <= '0;
        else if (wr_hi && ctrl_q.buf16)   shadow_q <= bus_wdata;
        else if (rd_lo && ctrl_q.buf16)   shadow_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (wr_ctl) ctrl_q <= ctrl_t'(bus_wdata & 8'hBF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_int) ie_q <= bus_wdata[1];
            if (ovf)                         flag_q <= 1'b1;
            else if (wr_int && !bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && ie_q;

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = ctrl_q.buf16 ? shadow_q : cnt_q[CNT_W-1:BYTE_W];
            A_CTRL:   bus_rdata = ctrl_view(ctrl_q);
            default:  bus_rdata = {6'b0, ie_q, flag_q};
        endcase
    end

endmodule

// File: rtl/tmr16_core_chk.sv
module tmr16_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        evt_trig,
    input logic [15:0] cnt_q,
    input logic [7:0]  shadow_q,
    input logic        flag_q,
    input logic        buf16,
    input logic        ext_src,
    input logic        no_sync
);
    // R1
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(cnt_q) == 16'hFFFF && cnt_q == 16'h0000));

    // R3
    ctrl_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> !bus_rdata[6]);

    // R6
    buf_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && buf16) |=> (cnt_q == {$past(shadow_q), $past(bus_wdata)}));

    // R7
    direct_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && !buf16) |=> (cnt_q[7:0] == $past(bus_wdata)));

    // R9
    trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_trig && !bus_wr && !(ext_src && no_sync)) |=> (cnt_q == 16'h0000));

    // R10
    trig_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_trig && !bus_wr && !(ext_src && no_sync) && !flag_q) |=> !flag_q);

endmodule

bind tmr16_core tmr16_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_trig  (evt_trig),
    .cnt_q     (cnt_q),
    .shadow_q  (shadow_q),
    .flag_q    (flag_q),
    .buf16     (ctrl_q.buf16),
    .ext_src   (ctrl_q.ext_src),
    .no_sync   (ctrl_q.no_sync)
);

// File: tb/tmr16_core_test.sv
`timescale 1ns/1ps
module tmr16_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       ext_pulse = 1'b0;
    logic       evt_trig = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr16_core uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .ext_pulse(ext_pulse), .evt_trig(evt_trig), .irq(irq)
    );

    // {div code[42:41], start[40:25], ticks[24:17], expected[16:1], flag[0]}
    localparam logic [42:0] VEC [6] = '{
        {2'd0, 16'h0010, 8'd5,  16'h0015, 1'b0},
        {2'd1, 16'h0100, 8'd6,  16'h0103, 1'b0},
        {2'd2, 16'h0000, 8'd9,  16'h0002, 1'b0},
        {2'd3, 16'h1234, 8'd16, 16'h1236, 1'b0},
        {2'd0, 16'hFFFE, 8'd3,  16'h0001, 1'b1},
        {2'd3, 16'hFFFF, 8'd7,  16'hFFFF, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic preset(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 / R3 reset state
        rd(2'd2, b); chk("R3 ctrl reset", 16'(b), 16'h00);
        rd16(v);     chk("R12 count reset", v, 16'h0000);
        rd(2'd3, b); chk("R12 int reg reset", 16'(b), 16'h00);
        chk("R12 irq reset", 16'(irq), 16'h0);

        // R3 unused bit reads 0, other bits stored
        wr(2'd2, 8'hFF);
        rd(2'd2, b); chk("R3 ctrl readback", 16'(b), 16'hBF);
        wr(2'd2, 8'h00);

        // R4 / R1 / R2 table of prescaler runs
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, {2'b00, VEC[i][42:41], 4'b0001});
            preset(VEC[i][40:25]);
            wr(2'd3, 8'h00);
            ticks(int'(VEC[i][24:17]));
            rd16(v);
            chk($sformatf("R4 R1 vector %0d count", i), v, VEC[i][16:1]);
            rd(2'd3, b);
            chk($sformatf("R1 vector %0d flag", i), 16'(b), 16'(VEC[i][0]));
            chk($sformatf("R2 vector %0d irq masked", i), 16'(irq), 16'h0);
        end

        // R5 buffered read capture
        wr(2'd2, 8'h01);
        preset(16'h00FE);
        wr(2'd2, 8'h81);
        rd(2'd0, b); chk("R5 low read", 16'(b), 16'hFE);
        ticks(2);
        rd(2'd1, b); chk("R5 high from shadow", 16'(b), 16'h00);
        rd(2'd0, b); chk("R5 low after carry", 16'(b), 16'h00);
        rd(2'd1, b); chk("R5 high recaptured", 16'(b), 16'h01);

        // R6 buffered write commit
        wr(2'd1, 8'hAB);
        rd(2'd1, b); chk("R6 shadow written", 16'(b), 16'hAB);
        rd(2'd0, b);
        rd(2'd1, b); chk("R6 live high untouched", 16'(b), 16'h01);
        wr(2'd1, 8'hAB);
        wr(2'd0, 8'hCD);
        rd16(v);     chk("R6 16-bit commit", v, 16'hABCD);

        // R7 direct access
        wr(2'd2, 8'h01);
        rd(2'd1, b); chk("R7 direct high read", 16'(b), 16'hAB);
        wr(2'd1, 8'h5A);
        rd16(v);     chk("R7 direct high write", v, 16'h5ACD);

        // R8 prescaler clear rules, divide by 8
        wr(2'd2, 8'h31);
        preset(16'h0000);
        ticks(4); wr(2'd1, 8'h00); ticks(4);
        rd16(v);     chk("R8 high write keeps phase", v, 16'h0001);
        ticks(4); wr(2'd0, 8'h00); ticks(4);
        rd16(v);     chk("R8 low write clears phase", v, 16'h0000);

        // R9 trigger in timer mode
        wr(2'd2, 8'h01);
        preset(16'h0050);
        wr(2'd3, 8'h00);
        @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd16(v);     chk("R9 timer trigger clears", v, 16'h0000);

        // R10 trigger against wrap: no flag
        preset(16'hFFFF);
        @(negedge clk); evt_trig = 1'b1; tick_en = 1'b1;
        @(negedge clk); evt_trig = 1'b0; tick_en = 1'b0;
        rd16(v);     chk("R10 trigger at max", v, 16'h0000);
        rd(2'd3, b); chk("R10 trigger no flag", 16'(b), 16'h00);

        // R10 write beats trigger
        preset(16'h1234);
        @(negedge clk); evt_trig = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk); evt_trig = 1'b0; bus_wr = 1'b0;
        rd16(v);     chk("R10 write wins", v, 16'h1277);

        // R9 / R11 unsynchronized counter mode
        wr(2'd2, 8'h07);
        preset(16'h0040);
        @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd16(v);     chk("R9 async trigger ignored", v, 16'h0040);
        @(negedge clk); ext_pulse = 1'b1;
        repeat (3) @(negedge clk);
        ext_pulse = 1'b0;
        rd16(v);     chk("R11 level counting", v, 16'h0043);

        // R11 / R9 synchronized counter mode
        wr(2'd2, 8'h03);
        preset(16'h0010);
        @(negedge clk); ext_pulse = 1'b1;
        repeat (5) @(negedge clk);
        ext_pulse = 1'b0;
        repeat (4) @(negedge clk);
        rd16(v);     chk("R11 one edge one count", v, 16'h0011);
        @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd16(v);     chk("R9 sync trigger clears", v, 16'h0000);

        // R2 flag set versus clear, enable gating
        wr(2'd2, 8'h01);
        preset(16'hFFFF);
        wr(2'd3, 8'h02);
        chk("R2 irq idle", 16'(irq), 16'h0);
        @(negedge clk); tick_en = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
        rd(2'd3, b); chk("R2 set beats clear", 16'(b), 16'h03);
        chk("R2 irq raised", 16'(irq), 16'h1);
        wr(2'd3, 8'h01);
        rd(2'd3, b); chk("R2 write 1 keeps flag", 16'(b), 16'h01);
        chk("R2 irq masked by enable", 16'(irq), 16'h0);
        wr(2'd3, 8'h00);
        rd(2'd3, b); chk("R2 write 0 clears", 16'(b), 16'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule